// File: doc/BRIEF.md
# Multi-Lane Serial Memory Read Engine

This block is the slave-side read path of a serial static memory whose data bus can run one, two or four lanes wide. The serial clock `sck` clocks the whole engine, and the chip select `cs_n` frames each transfer. While `cs_n` is low, the engine first collects an 8-bit opcode on the active lanes and then a 24-bit address. It lets one byte's worth of clocks pass as a dummy gap. After that it drives stored bytes back on the same lanes, most significant chunk first, one byte after another, for as long as clocks keep coming.

The storage array is outside the block. The engine presents a 17-bit byte address on `mem_addr` and reads the byte it returns on `mem_rdata` combinationally. The bidirectional pads are split into an output value `sio_out` and a per-lane enable `sio_oe`. The pad ring builds the tri-state buffers from these two signals. The lane width comes from the static input `lane_mode`, which must change only while `cs_n` is high.

Top module: `srd_engine`

## Requirements
- R1: Inputs are sampled on the rising edge of `sck`. The first 8 bits of a frame form the opcode, sent most significant bit first. Only the opcode value 0x03 starts a read.
- R2: `lane_mode` selects the lane width. 2'b00 uses one lane: input on `sio_in[0]` and output on `sio_out[1]`. 2'b01 uses two lanes on bits [1:0], with bit 1 carrying the higher-order bit. 2'b10 uses four lanes on bits [3:0], with bit 3 carrying the highest-order bit. 2'b11 behaves like 2'b00.
- R3: The 24-bit address follows the opcode, most significant bit first. It takes 24, 12 or 6 clocks for one, two or four lanes.
- R4: Only the low 17 bits of the received address are used. The upper 7 bits have no effect on the bytes returned.
- R5: One dummy byte follows the address: 8, 4 or 2 clocks for one, two or four lanes. No lane is driven during it.
- R6: Each byte is sent as 8, 4 or 2 chunks, highest-order chunk first. Each chunk is driven on a falling edge of `sck` and held across the next rising edge. The first chunk appears on the falling edge that follows the last dummy clock.
- R7: The byte address advances by one after each full byte, wraps from 0x1FFFF to 0x00000, and output continues for as long as clocks arrive.
- R8: `sio_oe` is set only on the lanes of the selected width, and only during the data phase. While a lane is released, its `sio_out` bit is 0.
- R9: After an opcode other than 0x03, the rest of the frame is ignored and every lane stays released until `cs_n` rises.
- R10: `cs_n` going high at any moment aborts the transfer at once. It releases all lanes, and the next frame starts again with opcode reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock: inputs sampled on the rising edge, outputs changed on the falling edge |
| cs_n | input | 1 | Active-low chip select; high asynchronously resets the engine |
| lane_mode | input | 2 | Static lane width select: 00 one, 01 two, 10 four, 11 one |
| sio_in | input | 4 | Values received from the serial data pads |
| sio_out | output | 4 | Values to drive onto the serial data pads |
| sio_oe | output | 4 | Per-lane drive enable for the serial data pads |
| mem_addr | output | 17 | Byte address into the external storage array |
| mem_rdata | input | 8 | Byte read combinationally from the storage array at `mem_addr` |

## Verification
The bench builds the engine with its default parameters: a 17-bit array address inside a 24-bit address field, 8-bit opcode and data, and a single dummy byte. Under this build, every lane mode, the wrap from the top of the array to zero, and the discarding of the upper address bits can all be reached within short frames. The directed scenarios cover reads in every mode, including the reserved code, reads across the wrap, an address with its upper bits set, a rejected opcode, and chip-select aborts during the address and the data phase. Each scenario compares the bytes gathered from the lanes with a memory model in the bench.

// File: rtl/srd_pkg.sv
package srd_pkg;
   localparam int NUM_LANES = 4;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR,
      PH_DUMMY,
      PH_DATA,
      PH_HALT
   } phase_t;

   // log2 of bits carried per clock for a lane_mode code
   function automatic logic [1:0] lane_shift(input logic [1:0] mode);
      case (mode)
         2'b01:   return 2'd1;
         2'b10:   return 2'd2;
         default: return 2'd0;
      endcase
   endfunction

   // lanes driven during the data phase for a given shift
   function automatic logic [NUM_LANES-1:0] lane_mask(input logic [1:0] sh);
      case (sh)
         2'd1:    return 4'b0011;
         2'd2:    return 4'b1111;
         default: return 4'b0010;
      endcase
   endfunction
endpackage

// File: rtl/srd_seq.sv
module srd_seq
   import srd_pkg::*;
#(
   parameter int ADDR_W       = 17,
   parameter int FRAME_ADDR_W = 24,
   parameter int CMD_W        = 8,
   parameter int DATA_W       = 8,
   parameter int DUMMY_BYTES  = 1,
   parameter logic [CMD_W-1:0] CMD_READ = 'h03,
   localparam int BEAT_W      = $clog2(DATA_W)
) (
   input  logic              sck,
   input  logic              cs_n,
   input  logic [1:0]        lane_mode,
   input  logic [3:0]        sio_in,
   output phase_t            phase_o,
   output logic [BEAT_W-1:0] beat_o,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int SHR_W      = CMD_W + FRAME_ADDR_W;
   localparam int DUMMY_BITS = DUMMY_BYTES * DATA_W;
   localparam int CNT_W      = $clog2(FRAME_ADDR_W);

   generate
      if (ADDR_W > FRAME_ADDR_W) begin : g_bad_addr
         $error("ADDR_W exceeds FRAME_ADDR_W");
      end
      if ((CMD_W % 4) != 0 || (DATA_W % 4) != 0 || (FRAME_ADDR_W % 4) != 0) begin : g_bad_align
         $error("field widths must be multiples of four");
      end
      if (CMD_W > FRAME_ADDR_W || DATA_W > FRAME_ADDR_W || DUMMY_BITS > FRAME_ADDR_W) begin : g_bad_cnt
         $error("phase counter sized by FRAME_ADDR_W is too small");
      end
   endgenerate

   logic [1:0]        sh;
   logic [SHR_W-1:0]  shreg, shreg_nxt;
   logic [CNT_W-1:0]  cnt;
   phase_t            phase, after_addr;
   logic [BEAT_W-1:0] beat, beat_last;
   logic [ADDR_W-1:0] addr;

   function automatic logic [CNT_W-1:0] last_of(input int bits, input logic [1:0] s);
      return CNT_W'((bits >> s) - 1);
   endfunction

   generate
      if (DUMMY_BYTES > 0) begin : g_dummy
         assign after_addr = PH_DUMMY;
      end else begin : g_no_dummy
         assign after_addr = PH_DATA;
      end
   endgenerate

   assign sh        = lane_shift(lane_mode);
   assign beat_last = BEAT_W'((DATA_W >> sh) - 1);

   always_comb begin
      case (sh)
         2'd1:    shreg_nxt = {shreg[SHR_W-3:0], sio_in[1:0]};
         2'd2:    shreg_nxt = {shreg[SHR_W-5:0], sio_in[3:0]};
         default: shreg_nxt = {shreg[SHR_W-2:0], sio_in[0]};
      endcase
   end

   always_ff @(posedge sck or posedge cs_n) begin
      if (cs_n) begin
         phase <= PH_CMD;
         cnt   <= '0;
         beat  <= '0;
         addr  <= '0;
         shreg <= '0;
      end else begin
         case (phase)
            PH_CMD: begin
               shreg <= shreg_nxt;
               if (cnt == last_of(CMD_W, sh)) begin
                  cnt   <= '0;
                  phase <= (shreg_nxt[CMD_W-1:0] == CMD_READ) ? PH_ADDR : PH_HALT;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_ADDR: begin
               shreg <= shreg_nxt;
               if (cnt == last_of(FRAME_ADDR_W, sh)) begin
                  cnt   <= '0;
                  addr  <= shreg_nxt[ADDR_W-1:0];
                  beat  <= '0;
                  phase <= after_addr;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_DUMMY: begin
               if (cnt == last_of(DUMMY_BITS, sh)) begin
                  cnt   <= '0;
                  phase <= PH_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_DATA: begin
               if (beat == beat_last) begin
                  beat <= '0;
                  addr <= addr + 1'b1;
               end else begin
                  beat <= beat + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign phase_o = phase;
   assign beat_o  = beat;
   assign addr_o  = addr;

   AST_DATA_AFTER_GAP: assert property (@(posedge sck) disable iff (cs_n)
      (phase == PH_DATA && $past(phase) != PH_DATA) |-> ($past(phase) == after_addr)); // R5
   AST_ADDR_STEP: assert property (@(posedge sck) disable iff (cs_n)
      (phase == PH_DATA && $past(phase) == PH_DATA && beat == '0)
         |-> (addr == ADDR_W'($past(addr) + 1'b1))); // R7
   AST_BEAT_RANGE: assert property (@(posedge sck) disable iff (cs_n)
      beat <= beat_last); // R6
   AST_HALT_STICKY: assert property (@(posedge sck) disable iff (cs_n)
      (phase == PH_HALT) |=> (phase == PH_HALT)); // R9
endmodule

// File: rtl/srd_drv.sv
module srd_drv
   import srd_pkg::*;
#(
   parameter int DATA_W  = 8,
   localparam int BEAT_W = $clog2(DATA_W)
) (
   input  logic              sck,
   input  logic              cs_n,
   input  logic [1:0]        lane_mode,
   input  phase_t            phase,
   input  logic [BEAT_W-1:0] beat,
   input  logic [DATA_W-1:0] rdata,
   output logic [3:0]        sio_out,
   output logic [3:0]        sio_oe
);
   logic [1:0]           sh;
   logic [DATA_W-1:0]    aligned;
   logic [NUM_LANES-1:0] chunk, mask;

   assign sh      = lane_shift(lane_mode);
   assign mask    = lane_mask(sh);
   assign aligned = rdata << (int'(beat) << sh);

   always_comb begin
      case (sh)
         2'd1:    chunk = {2'b00, aligned[DATA_W-1 -: 2]};
         2'd2:    chunk = aligned[DATA_W-1 -: 4];
         default: chunk = {2'b00, aligned[DATA_W-1], 1'b0};
      endcase
   end

   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         logic q_out, q_oe;
         always_ff @(negedge sck or posedge cs_n) begin
            if (cs_n) begin
               q_out <= 1'b0;
               q_oe  <= 1'b0;
            end else begin
               q_oe  <= (phase == PH_DATA) & mask[i];
               q_out <= (phase == PH_DATA) & chunk[i];
            end
         end
         assign sio_out[i] = q_out;
         assign sio_oe[i]  = q_oe;

         AST_QUIET_RELEASED: assert property (@(posedge sck) disable iff (cs_n)
            !q_oe |-> !q_out); // R8
      end
   endgenerate
endmodule

// File: rtl/srd_engine.sv
module srd_engine
   import srd_pkg::*;
#(
   parameter int ADDR_W       = 17,
   parameter int FRAME_ADDR_W = 24,
   parameter int CMD_W        = 8,
   parameter int DATA_W       = 8,
   parameter int DUMMY_BYTES  = 1,
   parameter logic [CMD_W-1:0] CMD_READ = 'h03
) (
   input  logic              sck,
   input  logic              cs_n,
   input  logic [1:0]        lane_mode,
   input  logic [3:0]        sio_in,
   output logic [3:0]        sio_out,
   output logic [3:0]        sio_oe,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int BEAT_W = $clog2(DATA_W);

   phase_t            phase;
   logic [BEAT_W-1:0] beat;

   srd_seq #(
      .ADDR_W(ADDR_W), .FRAME_ADDR_W(FRAME_ADDR_W), .CMD_W(CMD_W),
      .DATA_W(DATA_W), .DUMMY_BYTES(DUMMY_BYTES), .CMD_READ(CMD_READ)
   ) u_seq (
      .sck(sck), .cs_n(cs_n), .lane_mode(lane_mode), .sio_in(sio_in),
      .phase_o(phase), .beat_o(beat), .addr_o(mem_addr)
   );

   srd_drv #(.DATA_W(DATA_W)) u_drv (
      .sck(sck), .cs_n(cs_n), .lane_mode(lane_mode), .phase(phase),
      .beat(beat), .rdata(mem_rdata), .sio_out(sio_out), .sio_oe(sio_oe)
   );

   AST_OE_IN_DATA: assert property (@(posedge sck) disable iff (cs_n)
      (|sio_oe) |-> (phase == PH_DATA)); // R8
   AST_OE_WIDTH: assert property (@(posedge sck) disable iff (cs_n)
      (|sio_oe) |-> ($countones(sio_oe) == (1 << lane_shift(lane_mode)))); // R2
   AST_RELEASE_ON_DESELECT: assert property (@(posedge sck)
      cs_n |-> (sio_oe == 4'b0000)); // R10
endmodule

// File: tb/tb_srd_engine.sv
module tb_srd_engine;
   logic        sck = 1'b0;
   logic        cs_n = 1'b1;
   logic [1:0]  lane_mode = 2'b00;
   logic [3:0]  sio_in = 4'h0;
   logic [3:0]  sio_out, sio_oe;
   logic [16:0] mem_addr;
   logic [7:0]  mem_rdata;
   int n_checks = 0, n_fail = 0;
   bit finished = 0;

   always #4 sck = ~sck;

   function automatic logic [7:0] byte_at(input logic [16:0] a);
      return a[7:0] ^ a[16:9] ^ 8'h5A;
   endfunction

   assign mem_rdata = byte_at(mem_addr);

   srd_engine dut (
      .sck(sck), .cs_n(cs_n), .lane_mode(lane_mode), .sio_in(sio_in),
      .sio_out(sio_out), .sio_oe(sio_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int shift_of(input logic [1:0] m);
      return (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : 0;
   endfunction

   function automatic logic [3:0] mask_of(input logic [1:0] m);
      return (m == 2'b01) ? 4'b0011 : (m == 2'b10) ? 4'b1111 : 4'b0010;
   endfunction

   // Drives opcode and address, then n_in more dummy-phase clocks of zero.
   // Returns 1 in released when no lane was enabled while doing so.
   task automatic send_head(input logic [1:0] m, input logic [7:0] op, input logic [23:0] a,
                            input int n_in, output bit released);
      int bpc = 1 << shift_of(m);
      logic [31:0] word = {op, a};
      released = 1;
      lane_mode = m;
      @(negedge sck);
      cs_n = 1'b0;
      for (int k = 0; k < 32 / bpc + n_in; k++) begin
         logic [31:0] w;
         w = (k < 32 / bpc) ? (word << (k * bpc)) : 32'h0;
         case (bpc)
            2:       sio_in = {2'b00, w[31:30]};
            4:       sio_in = w[31:28];
            default: sio_in = {3'b000, w[31]};
         endcase
         @(posedge sck);
         #1;
         if (sio_oe != 4'b0000) released = 0;
         @(negedge sck);
      end
      sio_in = 4'h0;
   endtask

   task automatic read_bytes(input logic [1:0] m, input logic [16:0] base, input int n, input string req);
      int sh = shift_of(m);
      int bpc = 1 << sh;
      for (int b = 0; b < n; b++) begin
         logic [7:0] got = '0;
         logic [16:0] ea = base + 17'(b);
         bit oe_ok = 1;
         for (int c = 0; c < 8 / bpc; c++) begin
            @(posedge sck);
            #1;
            if (sio_oe != mask_of(m)) oe_ok = 0;
            case (bpc)
               2:       got = {got[5:0], sio_out[1:0]};
               4:       got = {got[3:0], sio_out[3:0]};
               default: got = {got[6:0], sio_out[1]};
            endcase
         end
         chk(got == byte_at(ea), req, got, byte_at(ea));
         chk(oe_ok, {req, " R8 lane enables"}, 0, 1);
      end
   endtask

   task automatic end_frame();
      @(negedge sck);
      cs_n = 1'b1;
      @(negedge sck);
   endtask

   task automatic t_reset_state();
      repeat (3) @(posedge sck);
      #1;
      chk(sio_oe == 4'b0000, "R10 deselected released", sio_oe, 0);
      chk(sio_out == 4'b0000, "R8 released lanes low", sio_out, 0);
   endtask

   task automatic t_single();
      bit rel;
      send_head(2'b00, 8'h03, 24'h000123, 8, rel);
      chk(rel, "R5 single no drive before data", 0, 1);
      read_bytes(2'b00, 17'h00123, 3, "R1 R3 R6 single lane");
      end_frame();
   endtask

   task automatic t_dual_wrap();
      bit rel;
      send_head(2'b01, 8'h03, 24'h01FFFE, 4, rel);
      chk(rel, "R5 dual no drive before data", 0, 1);
      read_bytes(2'b01, 17'h1FFFE, 4, "R7 dual wrap");
      end_frame();
   endtask

   task automatic t_quad_upper();
      bit rel;
      send_head(2'b10, 8'h03, 24'hFE0040, 2, rel);
      chk(rel, "R5 quad no drive before data", 0, 1);
      read_bytes(2'b10, 17'h00040, 3, "R4 quad upper bits ignored");
      end_frame();
   endtask

   task automatic t_reserved_mode();
      bit rel;
      send_head(2'b11, 8'h03, 24'h0000A5, 8, rel);
      read_bytes(2'b11, 17'h000A5, 1, "R2 code 11 acts as one lane");
      end_frame();
   endtask

   task automatic t_bad_opcode();
      bit rel;
      send_head(2'b10, 8'h02, 24'h000010, 24, rel);
      chk(rel, "R9 rejected opcode keeps lanes released", 0, 1);
      end_frame();
   endtask

   task automatic t_abort_addr();
      bit rel;
      lane_mode = 2'b10;
      @(negedge sck);
      cs_n = 1'b0;
      sio_in = 4'h0; @(negedge sck);
      sio_in = 4'h3; @(negedge sck);
      sio_in = 4'h1; @(negedge sck);
      sio_in = 4'hF; @(negedge sck);
      cs_n = 1'b1;
      @(negedge sck);
      send_head(2'b10, 8'h03, 24'h000777, 2, rel);
      read_bytes(2'b10, 17'h00777, 2, "R10 frame after address abort");
      end_frame();
   endtask

   task automatic t_abort_data();
      bit rel;
      send_head(2'b01, 8'h03, 24'h000200, 4, rel);
      read_bytes(2'b01, 17'h00200, 1, "R6 dual before abort");
      @(posedge sck);
      #2;
      cs_n = 1'b1;
      #1;
      chk(sio_oe == 4'b0000, "R10 abort in data releases lanes", sio_oe, 0);
      @(negedge sck);
   endtask

   initial begin
      t_reset_state();
      t_single();
      t_dual_wrap();
      t_quad_upper();
      t_reserved_mode();
      t_bad_opcode();
      t_abort_addr();
      t_abort_data();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge sck);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule